// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block keeps the valid, dirty and tag bits of a direct-mapped cache and carries out maintenance on them. A requester issues commands on one write port. Three commands act on the single line that holds an address: clean, invalidate, and clean followed by invalidate. Two more act on a range of lines. The requester first stores a start address, then writes an end address. The end write starts a walk that visits lines one at a time, 32 bytes apart. One further command clears the valid bit of every set.

While work is in progress, `busy` is high and the requester must hold off. Any command or fill offered during that time is dropped. A clean that finds a valid dirty line raises a write-back request on a valid/ready port and waits there until the request is taken. An end address that lies outside the 4 KB page of the start address is refused with a one-cycle error pulse. A fill port loads lines into the tag store, and a combinational probe port reports whether an address hits and whether that line is dirty.

Top module: `range_maint_engine`

## Requirements
- R1: After reset, `busy`, `done`, `range_err` and `wb_valid` are low and no address hits on the probe port.
- R2: A range walk visits every 32-byte line whose first byte address is at or above the stored start and at or below the written end, and no other line. A start address that is not line aligned rounds up to the next line. A line is acted on only when its set is valid and its tag matches, so an aliasing address in the same set is left alone.
- R3: If bits [31:12] of the end address differ from those of the stored start, `range_err` is high for exactly the next cycle, `busy` stays low, and no line changes.
- R4: `busy` is high from the cycle after an accepted line, range or clear-all command until the last line is finished. `busy` stays high for one cycle per line visited plus one cycle per write-back. `done` is high for one cycle, in the first cycle `busy` is low again. Commands and fills offered while `busy` is high are ignored.
- R5: Clean on a valid dirty line makes one write-back request with the line-aligned address, then clears the dirty bit and keeps the line valid. Clean on a line that is not dirty makes no request.
- R6: Invalidate clears the valid bit without any write-back, even when the line is dirty.
- R7: Clean-and-invalidate on a dirty line requests the write-back first. The line stays valid until that request is accepted, and is invalid afterwards.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_valid` stays high, `wb_addr` holds, and the walker does not move to another line.
- R9: Clear-all clears the valid bit of every set, makes no write-back request, and keeps `busy` high for one cycle per set.
- R10: Command codes on `cmd_op`: 0 clean line, 1 invalidate line, 2 clean-and-invalidate line, 3 clear all, 4 store range start, 5 clean range to end, 6 invalidate range to end, 7 no effect. A same-page range whose rounded start lies above its end visits no line: `done` pulses in the next cycle and `busy` stays low.
- R11: A fill while idle makes the line of `fill_addr` valid, stores its tag and sets its dirty bit from `fill_dirty`. The probe reports hit and dirty in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_op | input | 3 | Command code (see R10) |
| cmd_addr | input | 32 | Command address |
| busy | output | 1 | Engine working; requester must stall |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | One-cycle pulse for a page-crossing range |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_addr | output | 32 | Line-aligned write-back address |
| fill_en | input | 1 | Load a line into the tag store |
| fill_addr | input | 32 | Address of the line to load |
| fill_dirty | input | 1 | Dirty state of the loaded line |
| probe_addr | input | 32 | Address to look up |
| probe_hit | output | 1 | Probe address is valid with matching tag |
| probe_dirty | output | 1 | Probed line is dirty |

## Verification
The output timing is fixed relative to the command. `range_err`, or the `done` of an empty range, appears one cycle after the accepting edge. `busy` rises in that same cycle and stays high for exactly one cycle per visited line plus one per write-back. `done` appears in the first cycle after that, and a write-back request appears in the cycle after its line is examined. The bench drives inputs on the falling edge and reads outputs on the next falling edge. It counts `busy` cycles against a count worked out from a line-level model of the range. Write-back handshakes are counted on the rising edge. Tag state is read through the probe port only after `done`.

// File: rtl/rme_pkg.sv
package rme_pkg;

    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int PAGE_OFF   = 12;
    localparam int LINE_W     = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [2:0] {
        OP_CLEAN_LINE = 3'd0,
        OP_INV_LINE   = 3'd1,
        OP_FLUSH_LINE = 3'd2,
        OP_INV_ALL    = 3'd3,
        OP_SET_START  = 3'd4,
        OP_CLEAN_END  = 3'd5,
        OP_INV_END    = 3'd6,
        OP_NONE       = 3'd7
    } op_e;

    typedef struct packed {
        logic do_clean;
        logic do_inv;
    } mode_t;

    typedef struct packed {
        line_t first;
        line_t last;
        mode_t mode;
    } walk_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_WALK,
        W_WB,
        W_SWEEP
    } wstate_e;

    function automatic line_t line_of(addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic logic same_page(addr_t a, addr_t b);
        return a[ADDR_W-1:PAGE_OFF] == b[ADDR_W-1:PAGE_OFF];
    endfunction

endpackage

// File: rtl/rme_cmd_decode.sv
module rme_cmd_decode
    import rme_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  addr_t       cmd_addr,
    input  logic        busy,
    output logic        launch,
    output walk_t       launch_req,
    output logic        sweep_go,
    output logic        empty_go,
    output logic        range_err
);

    addr_t             start_q;
    op_e               op;
    logic              accept;
    logic              err_now;
    logic [LINE_W:0]   first_ext;
    logic [LINE_W:0]   last_ext;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid & ~busy;

    // first line whose first byte is not below the start address
    assign first_ext = {1'b0, line_of(start_q)}
                     + {{LINE_W{1'b0}}, |start_q[OFF_W-1:0]};
    assign last_ext  = {1'b0, line_of(cmd_addr)};

    always_comb begin
        launch          = 1'b0;
        sweep_go        = 1'b0;
        empty_go        = 1'b0;
        err_now         = 1'b0;
        launch_req.first = line_of(cmd_addr);
        launch_req.last  = line_of(cmd_addr);
        launch_req.mode  = '0;
        if (accept) begin
            unique case (op)
                OP_CLEAN_LINE: begin
                    launch = 1'b1;
                    launch_req.mode = '{do_clean: 1'b1, do_inv: 1'b0};
                end
                OP_INV_LINE: begin
                    launch = 1'b1;
                    launch_req.mode = '{do_clean: 1'b0, do_inv: 1'b1};
                end
                OP_FLUSH_LINE: begin
                    launch = 1'b1;
                    launch_req.mode = '{do_clean: 1'b1, do_inv: 1'b1};
                end
                OP_INV_ALL: begin
                    sweep_go = 1'b1;
                end
                OP_CLEAN_END, OP_INV_END: begin
                    launch_req.mode.do_clean = (op == OP_CLEAN_END);
                    launch_req.mode.do_inv   = (op == OP_INV_END);
                    launch_req.first         = first_ext[LINE_W-1:0];
                    if (!same_page(start_q, cmd_addr)) begin
                        err_now = 1'b1;
                    end else if (first_ext > last_ext) begin
                        empty_go = 1'b1;
                    end else begin
                        launch = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= '0;
            range_err <= 1'b0;
        end else begin
            range_err <= err_now;
            if (accept && op == OP_SET_START) begin
                start_q <= cmd_addr;
            end
        end
    end

endmodule

// File: rtl/rme_tag_store.sv
module rme_tag_store
    import rme_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  line_t            fill_line,
    input  logic             fill_dirty,
    input  line_t            look_line,
    output logic             look_hit,
    output logic             look_dirty,
    input  logic             upd_en,
    input  logic             clr_valid,
    input  logic             clr_dirty,
    input  logic             sweep_en,
    input  logic [IDX_W-1:0] sweep_idx,
    input  line_t            probe_line,
    output logic             probe_hit,
    output logic             probe_dirty
);

    localparam int TAG_W = LINE_W - IDX_W;

    typedef logic [TAG_W-1:0] tag_t;

    logic valid_q [SETS];
    logic dirty_q [SETS];
    tag_t tag_q   [SETS];

    logic [IDX_W-1:0] fill_idx, look_idx, probe_idx;

    assign fill_idx  = fill_line[IDX_W-1:0];
    assign look_idx  = look_line[IDX_W-1:0];
    assign probe_idx = probe_line[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
                tag_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < SETS; i++) begin
                if (sweep_en && sweep_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b0;
                end else if (upd_en && look_idx == IDX_W'(i)) begin
                    if (clr_valid) valid_q[i] <= 1'b0;
                    if (clr_dirty) dirty_q[i] <= 1'b0;
                end else if (fill_en && fill_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= fill_dirty;
                    tag_q[i]   <= fill_line[LINE_W-1:IDX_W];
                end
            end
        end
    end

    assign look_hit    = valid_q[look_idx] && (tag_q[look_idx] == look_line[LINE_W-1:IDX_W]);
    assign look_dirty  = dirty_q[look_idx];
    assign probe_hit   = valid_q[probe_idx] && (tag_q[probe_idx] == probe_line[LINE_W-1:IDX_W]);
    assign probe_dirty = probe_hit & dirty_q[probe_idx];

endmodule

// File: rtl/rme_walker.sv
module rme_walker
    import rme_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  walk_t            launch_req,
    input  logic             sweep_go,
    input  logic             empty_go,
    input  logic             look_hit,
    input  logic             look_dirty,
    input  logic             wb_ready,
    output line_t            look_line,
    output logic             busy,
    output logic             done,
    output logic             wb_valid,
    output logic             upd_en,
    output logic             clr_valid,
    output logic             clr_dirty,
    output logic             sweep_en,
    output logic [IDX_W-1:0] sweep_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

    wstate_e          state_q;
    line_t            cur_q;
    line_t            last_q;
    mode_t            mode_q;
    logic [IDX_W-1:0] sidx_q;
    logic             need_wb;
    logic             at_last;

    assign need_wb   = look_hit & look_dirty & mode_q.do_clean;
    assign at_last   = (cur_q == last_q);
    assign look_line = cur_q;
    assign busy      = (state_q != W_IDLE);
    assign wb_valid  = (state_q == W_WB);
    assign sweep_en  = (state_q == W_SWEEP);
    assign sweep_idx = sidx_q;

    always_comb begin
        upd_en    = 1'b0;
        clr_valid = 1'b0;
        clr_dirty = 1'b0;
        unique case (state_q)
            W_WALK: begin
                if (look_hit && !need_wb && mode_q.do_inv) begin
                    upd_en    = 1'b1;
                    clr_valid = 1'b1;
                end
            end
            W_WB: begin
                if (wb_ready) begin
                    upd_en    = 1'b1;
                    clr_dirty = 1'b1;
                    clr_valid = mode_q.do_inv;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
            mode_q  <= '0;
            sidx_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                W_IDLE: begin
                    done <= empty_go;
                    if (launch) begin
                        state_q <= W_WALK;
                        cur_q   <= launch_req.first;
                        last_q  <= launch_req.last;
                        mode_q  <= launch_req.mode;
                    end else if (sweep_go) begin
                        state_q <= W_SWEEP;
                        sidx_q  <= '0;
                    end
                end
                W_WALK: begin
                    if (need_wb) begin
                        state_q <= W_WB;
                    end else if (at_last) begin
                        state_q <= W_IDLE;
                        done    <= 1'b1;
                    end else begin
                        cur_q <= cur_q + 1'b1;
                    end
                end
                W_WB: begin
                    if (wb_ready) begin
                        if (at_last) begin
                            state_q <= W_IDLE;
                            done    <= 1'b1;
                        end else begin
                            state_q <= W_WALK;
                            cur_q   <= cur_q + 1'b1;
                        end
                    end
                end
                W_SWEEP: begin
                    if (sidx_q == LAST_IDX) begin
                        state_q <= W_IDLE;
                        done    <= 1'b1;
                    end else begin
                        sidx_q <= sidx_q + 1'b1;
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/range_maint_engine.sv
module range_maint_engine
    import rme_pkg::*;
#(
    parameter int SETS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [31:0] cmd_addr,
    output logic        busy,
    output logic        done,
    output logic        range_err,
    output logic        wb_valid,
    input  logic        wb_ready,
    output logic [31:0] wb_addr,
    input  logic        fill_en,
    input  logic [31:0] fill_addr,
    input  logic        fill_dirty,
    input  logic [31:0] probe_addr,
    output logic        probe_hit,
    output logic        probe_dirty
);

    localparam int IDX_W = $clog2(SETS);

    logic             launch, sweep_go, empty_go;
    walk_t            launch_req;
    line_t            look_line;
    logic             look_hit, look_dirty;
    logic             upd_en, clr_valid, clr_dirty;
    logic             sweep_en;
    logic [IDX_W-1:0] sweep_idx;

    rme_cmd_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .busy       (busy),
        .launch     (launch),
        .launch_req (launch_req),
        .sweep_go   (sweep_go),
        .empty_go   (empty_go),
        .range_err  (range_err)
    );

    rme_walker #(.SETS(SETS), .IDX_W(IDX_W)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_req (launch_req),
        .sweep_go   (sweep_go),
        .empty_go   (empty_go),
        .look_hit   (look_hit),
        .look_dirty (look_dirty),
        .wb_ready   (wb_ready),
        .look_line  (look_line),
        .busy       (busy),
        .done       (done),
        .wb_valid   (wb_valid),
        .upd_en     (upd_en),
        .clr_valid  (clr_valid),
        .clr_dirty  (clr_dirty),
        .sweep_en   (sweep_en),
        .sweep_idx  (sweep_idx)
    );

    rme_tag_store #(.SETS(SETS), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .fill_en     (fill_en & ~busy),
        .fill_line   (line_of(fill_addr)),
        .fill_dirty  (fill_dirty),
        .look_line   (look_line),
        .look_hit    (look_hit),
        .look_dirty  (look_dirty),
        .upd_en      (upd_en),
        .clr_valid   (clr_valid),
        .clr_dirty   (clr_dirty),
        .sweep_en    (sweep_en),
        .sweep_idx   (sweep_idx),
        .probe_line  (line_of(probe_addr)),
        .probe_hit   (probe_hit),
        .probe_dirty (probe_dirty)
    );

    assign wb_addr = {look_line, {OFF_W{1'b0}}};

endmodule

// File: rtl/rme_checker.sv
module rme_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        range_err,
    input logic        wb_valid,
    input logic        wb_ready,
    input logic [31:0] wb_addr
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !wb_valid && !done && !range_err));

    p_err_not_busy_r3: assert property (@(posedge clk) disable iff (rst)
        range_err |-> !busy);

    p_err_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        range_err |=> !range_err);

    p_done_on_busy_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_wb_inside_busy_r5: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> busy);

    p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

    p_wb_line_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_addr[4:0] == 5'd0));

endmodule

bind range_maint_engine rme_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .range_err (range_err),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_addr   (wb_addr)
);

// File: tb/range_maint_engine_tb.sv
module range_maint_engine_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic        busy, done, range_err, wb_valid;
    logic        wb_ready;
    logic [31:0] wb_addr;
    logic        fill_en;
    logic [31:0] fill_addr;
    logic        fill_dirty;
    logic [31:0] probe_addr;
    logic        probe_hit, probe_dirty;

    int total = 0;
    int bad   = 0;
    int wb_cnt = 0;
    logic [31:0] wb_last = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    range_maint_engine u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .busy(busy), .done(done), .range_err(range_err),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_dirty(probe_dirty)
    );

    always @(posedge clk) begin
        if (!rst && wb_valid && wb_ready) begin
            wb_cnt  <= wb_cnt + 1;
            wb_last <= wb_addr;
        end
    end

    // {invalidate, start, end}
    localparam logic [64:0] VEC [8] = '{
        {1'b0, 32'h0000_1000, 32'h0000_10E0},
        {1'b0, 32'h0000_1020, 32'h0000_1060},
        {1'b1, 32'h0000_1010, 32'h0000_1050},
        {1'b0, 32'h0000_10E0, 32'h0000_10E0},
        {1'b1, 32'h0000_1800, 32'h0000_18E0},
        {1'b0, 32'h0000_1000, 32'h0000_1FE0},
        {1'b0, 32'h0000_1040, 32'h0000_1040},
        {1'b1, 32'h0000_1000, 32'h0000_10FF}
    };

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [31:0] a);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic fill(input logic [31:0] a, input logic d);
        fill_en    = 1'b1;
        fill_addr  = a;
        fill_dirty = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic run_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic look(input logic [31:0] a, output logic h, output logic d);
        probe_addr = a;
        #1;
        h = probe_hit;
        d = probe_dirty;
    endtask

    // clear everything, then eight lines from 0x1000, even ones dirty
    task automatic setup();
        int c;
        send(3'd3, 32'h0);
        run_idle(c);
        for (int i = 0; i < 8; i++) fill(32'h1000 + 32 * i, (i % 2) == 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic h, d;
        int   c, w0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0;
        wb_ready = 1'b1; fill_en = 1'b0; fill_addr = '0; fill_dirty = 1'b0;
        probe_addr = 32'h1000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "range_err", range_err, 0);
        chk("R1", "wb_valid", wb_valid, 0);
        look(32'h1000, h, d);
        chk("R1", "probe_hit", h, 0);
        @(negedge clk);

        // R2 R4 R5 R6 vector table against a line model
        for (int v = 0; v < 8; v++) begin
            bit    inv;
            longint s, e, first, last, la;
            int    nl, ewb;
            bit    ev [8];
            bit    ed [8];
            inv = VEC[v][64];
            s   = VEC[v][63:32];
            e   = VEC[v][31:0];
            first = (s + 31) >> 5;
            last  = e >> 5;
            nl  = int'(last - first + 1);
            ewb = 0;
            for (int i = 0; i < 8; i++) begin
                ev[i] = 1'b1;
                ed[i] = (i % 2) == 0;
                la = (32'h1000 >> 5) + i;
                if (la >= first && la <= last) begin
                    if (!inv && ed[i]) begin ewb++; ed[i] = 1'b0; end
                    if (inv) ev[i] = 1'b0;
                end
            end
            setup();
            w0 = wb_cnt;
            send(3'd4, VEC[v][63:32]);
            send(inv ? 3'd6 : 3'd5, VEC[v][31:0]);
            run_idle(c);
            chk("R4", $sformatf("vec%0d busy cycles", v), c, nl + ewb);
            chk("R4", $sformatf("vec%0d done", v), done, 1);
            chk("R5", $sformatf("vec%0d write-backs", v), wb_cnt - w0, ewb);
            for (int i = 0; i < 8; i++) begin
                look(32'h1000 + 32 * i, h, d);
                chk("R2", $sformatf("vec%0d line%0d hit", v, i), h, ev[i]);
                chk("R6", $sformatf("vec%0d line%0d dirty", v, i), d, ev[i] & ed[i]);
            end
            @(negedge clk);
        end

        // R3 page crossing
        setup();
        send(3'd4, 32'h1000);
        send(3'd5, 32'h2000);
        chk("R3", "err pulse", range_err, 1);
        chk("R3", "busy low", busy, 0);
        @(negedge clk);
        chk("R3", "err cleared", range_err, 0);
        look(32'h1000, h, d);
        chk("R3", "line untouched dirty", d, 1);
        @(negedge clk);

        // R10 empty range and unused code
        send(3'd4, 32'h1050);
        send(3'd5, 32'h1048);
        chk("R10", "empty done", done, 1);
        chk("R10", "empty busy", busy, 0);
        look(32'h1040, h, d);
        chk("R10", "empty untouched", d, 1);
        @(negedge clk);
        send(3'd7, 32'h1000);
        chk("R10", "code7 busy", busy, 0);
        chk("R10", "code7 done", done, 0);
        look(32'h1000, h, d);
        chk("R10", "code7 untouched", {h, d}, 2'b11);
        @(negedge clk);

        // R5 single clean, dirty and clean lines
        w0 = wb_cnt;
        send(3'd0, 32'h1044);
        run_idle(c);
        chk("R5", "clean busy cycles", c, 2);
        chk("R5", "clean wb count", wb_cnt - w0, 1);
        chk("R5", "clean wb addr", wb_last, 32'h1040);
        look(32'h1040, h, d);
        chk("R5", "clean keeps valid, clears dirty", {h, d}, 2'b10);
        @(negedge clk);
        w0 = wb_cnt;
        send(3'd0, 32'h1020);
        run_idle(c);
        chk("R5", "clean of clean line no wb", wb_cnt - w0, 0);

        // R6 single invalidate of dirty line
        w0 = wb_cnt;
        send(3'd1, 32'h1000);
        run_idle(c);
        chk("R6", "inv no wb", wb_cnt - w0, 0);
        look(32'h1000, h, d);
        chk("R6", "inv clears valid", h, 0);
        @(negedge clk);

        // R7 R8 clean-and-invalidate with stalled write-back
        wb_ready = 1'b0;
        w0 = wb_cnt;
        send(3'd2, 32'h1080);
        chk("R7", "no request while examining", wb_valid, 0);
        @(negedge clk);
        chk("R7", "request raised", wb_valid, 1);
        chk("R7", "request addr", wb_addr, 32'h1080);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8", "held valid", wb_valid, 1);
            chk("R8", "held addr", wb_addr, 32'h1080);
            look(32'h1080, h, d);
            chk("R7", "valid kept before accept", h, 1);
        end
        wb_ready = 1'b1;
        @(negedge clk);
        chk("R7", "done after accept", done, 1);
        chk("R7", "one wb", wb_cnt - w0, 1);
        look(32'h1080, h, d);
        chk("R7", "invalid after wb", h, 0);
        @(negedge clk);

        // R4 commands and fills ignored while busy
        setup();
        send(3'd4, 32'h1000);
        send(3'd5, 32'h10E0);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 32'h1020;
        fill_en = 1'b1; fill_addr = 32'h1100; fill_dirty = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; fill_en = 1'b0;
        run_idle(c);
        look(32'h1020, h, d);
        chk("R4", "cmd while busy ignored", h, 1);
        look(32'h1100, h, d);
        chk("R4", "fill while busy ignored", h, 0);
        @(negedge clk);

        // R9 clear all
        w0 = wb_cnt;
        send(3'd3, 32'h0);
        run_idle(c);
        chk("R9", "sweep busy cycles", c, 64);
        chk("R9", "sweep done", done, 1);
        chk("R9", "sweep no wb", wb_cnt - w0, 0);
        for (int i = 0; i < 8; i++) begin
            look(32'h1000 + 32 * i, h, d);
            chk("R9", $sformatf("line%0d invalid", i), h, 0);
        end
        @(negedge clk);

        // R11 fill and probe, alias miss
        fill(32'h2040, 1'b0);
        look(32'h2040, h, d);
        chk("R11", "fill clean hit", {h, d}, 2'b10);
        look(32'h3040, h, d);
        chk("R11", "alias miss", h, 0);
        @(negedge clk);
        fill(32'h2060, 1'b1);
        look(32'h2060, h, d);
        chk("R11", "fill dirty hit", {h, d}, 2'b11);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule